// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is the device side of a three-wire serial port. It lets an external controller load a bank of control registers. The controller opens a frame by pulling the enable line low. It then clocks in one bit per rising serial-clock edge. Each frame carries an 18-bit data word, most significant bit first, followed by a 6-bit address, with address bit 0 sent last. When the enable line rises, the data lands in the addressed register. Every register is presented at once on a flat parallel bus so that downstream logic can use the stored values.

Writes are gated by the power-down level. A frame is accepted only while the chip is held in power-down (`sleep_n` low). One exempt address can be written at any time. A read-only revision register sits at a parameter address. Writing a target address into it arms a readback: during the next enable-low frame, the target register is shifted out on `sdo`. Any later accepted write to another address cancels the readback. All three serial inputs are brought into the system clock domain through two-stage synchronizers, and the edges are detected on the synchronized copies.

Top module: `tri_wire_ctl_port`

## Requirements
- R1: A frame is a 24-bit word `{data[17:0], addr[5:0]}`, sent MSB first. On the synchronized rising edge of `sen`, the data is written to register `addr`. Register `i` appears on `regs_flat[i*18 +: 18]`, and the bus settles within 8 clock cycles of `sen` rising.
- R2: `sdi` is shifted only on `sclk` rising edges while `sen` is low. Clock edges while `sen` is high neither shift data nor count toward a frame.
- R3: When more than 24 bits are clocked into one frame, only the last 24 are used.
- R4: When `sen` rises after fewer than 24 bits, the frame is discarded and no register changes.
- R5: A frame is accepted only while `sleep_n` is low. The exception is address 0x22, which is accepted at any `sleep_n` level. A refused frame changes nothing, including the readback state.
- R6: The revision register at `REV_ADDR` (default 0x10) always reads `REV_VALUE` (default 18'h0A5C1) on the bus. Writes to it never change it.
- R7: An accepted write to `REV_ADDR` arms a readback of the register whose address is in data bits [5:0]. In the next `sen`-low frame, `sdo` presents that register's bits MSB first. The first bit appears shortly after `sen` falls, and each `sclk` rising edge advances one bit. After 18 bits, zeros follow.
- R8: An accepted write to any other address disarms readback. `sdo` is 0 whenever readback is not armed or `sen` is high.
- R9: Synchronous reset clears every writable register and the bit count to zero, disarms readback, and holds `sdo` at 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the controller |
| sen | input | 1 | Frame enable, active low |
| sdi | input | 1 | Serial data in |
| sleep_n | input | 1 | Power-down level; low means powered down and writable |
| sdo | output | 1 | Serial readback data |
| regs_flat | output | 64*18 | All registers, register i at bits [i*18 +: 18] |

## Verification
Readback shifting and a register write can fall in the same frame. While `sdo` streams out the armed register, the controller is clocking a new command frame in on `sdi`. The bench provokes this with a directed frame and with random frames that follow an arming write. It compares each `sdo` bit, sampled just before every `sclk` rise, against a model snapshot taken when the frame opened. After `sen` rises, it checks the committed register bus and the disarmed `sdo` against the model.

// File: rtl/tri_wire_ctl_port.sv
module tri_wire_ctl_port #(
  parameter int DW = 18,
  parameter int AW = 6,
  parameter logic [AW-1:0] REV_ADDR = 6'h10,
  parameter logic [AW-1:0] FREE_ADDR = 6'h22,
  parameter logic [DW-1:0] REV_VALUE = 18'h0A5C1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sclk,
  input  logic                      sen,
  input  logic                      sdi,
  input  logic                      sleep_n,
  output logic                      sdo,
  output logic [(1<<AW)*DW-1:0]     regs_flat
);
  localparam int FW = DW + AW;
  localparam int NR = 1 << AW;
  localparam int CW = $clog2(FW + 1);

  logic [2:0] sclk_q, sen_q;
  logic [1:0] sdi_q;
  logic [FW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [NR];
  logic [DW-1:0] out_sh;
  logic [AW-1:0] tgt;
  logic armed;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sen_s     = sen_q[1];
  wire sen_rise  = sen_q[1] & ~sen_q[2];
  wire sen_fall  = ~sen_q[1] & sen_q[2];
  wire [AW-1:0] f_addr = shreg[AW-1:0];
  wire [DW-1:0] f_data = shreg[FW-1:AW];
  wire accept = sen_rise && (cnt == CW'(FW)) && (!sleep_n || f_addr == FREE_ADDR);
  wire [DW-1:0] rd_word = (tgt == REV_ADDR) ? REV_VALUE : mem[tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      sen_q  <= '0;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sen_q  <= {sen_q[1:0], sen};
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sen_rise) begin
      cnt <= '0;
    end else if (sclk_rise && !sen_s) begin
      shreg <= {shreg[FW-2:0], sdi_q[1]};
      if (cnt != CW'(FW)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) mem[i] <= '0;
      armed <= 1'b0;
      tgt   <= '0;
    end else if (accept) begin
      if (f_addr == REV_ADDR) begin
        armed <= 1'b1;
        tgt   <= f_data[AW-1:0];
      end else begin
        mem[f_addr] <= f_data;
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_sh <= '0;
    else if (sen_fall) out_sh <= rd_word;
    else if (sclk_rise && !sen_s) out_sh <= {out_sh[DW-2:0], 1'b0};
  end

  assign sdo = armed & ~sen_s & out_sh[DW-1];

  for (genvar g = 0; g < NR; g++) begin : g_bus
    if (g == int'(REV_ADDR)) begin : g_rev
      assign regs_flat[g*DW +: DW] = REV_VALUE;
    end else begin : g_rw
      assign regs_flat[g*DW +: DW] = mem[g];
    end
  end

  p_regs_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !sen_rise |=> $stable(regs_flat));
  p_sen_high_r2: assert property (@(posedge clk) disable iff (rst)
    sen_s |=> $stable(shreg));
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FW));
  p_short_r4: assert property (@(posedge clk) disable iff (rst)
    (sen_rise && cnt != CW'(FW)) |=> $stable(regs_flat));
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (sen_rise && sleep_n && f_addr != FREE_ADDR) |=> $stable(regs_flat) && $stable(armed));
  p_rev_r6: assert property (@(posedge clk) disable iff (rst)
    regs_flat[int'(REV_ADDR)*DW +: DW] == REV_VALUE);
  p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && f_addr != REV_ADDR) |=> !armed && !sdo);
endmodule

// File: tb/tb_tri_wire_ctl_port.sv
module tb_tri_wire_ctl_port;
  localparam int DW = 18, AW = 6, NR = 64;
  localparam logic [5:0] REV = 6'h10, FREE = 6'h22;
  localparam logic [17:0] REVV = 18'h0A5C1;

  logic clk = 0, rst = 1, sclk = 0, sen = 1, sdi = 0, sleep_n = 0;
  logic sdo;
  logic [NR*DW-1:0] regs_flat;
  int total = 0, bad = 0;

  logic [17:0] mdl [NR];
  bit marm = 0;
  logic [5:0] mtgt = 0;

  tri_wire_ctl_port dut (.clk(clk), .rst(rst), .sclk(sclk), .sen(sen), .sdi(sdi),
    .sleep_n(sleep_n), .sdo(sdo), .regs_flat(regs_flat));

  always #10 clk = ~clk;

  function automatic logic [NR*DW-1:0] exp_flat();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = (i == int'(REV)) ? REVV : mdl[i];
    return v;
  endfunction

  task automatic chk(string req, logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_commit(int n, logic [31:0] st);
    logic [5:0] a;
    logic [17:0] d;
    if (n < 24) return;
    a = st[5:0];
    d = st[23:6];
    if (sleep_n && a != FREE) return;
    if (a == REV) begin
      marm = 1;
      mtgt = d[5:0];
    end else begin
      mdl[a] = d;
      marm = 0;
    end
  endtask

  task automatic frame(int n, logic [31:0] st, string req);
    logic [17:0] rb;
    bit arm0;
    arm0 = marm;
    rb = (mtgt == REV) ? REVV : mdl[mtgt];
    @(negedge clk) sen = 0;
    repeat (6) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      int k;
      k = n - 1 - i;
      sdi = st[i];
      repeat (4) @(negedge clk);
      chk({req, " R7/R8 sdo"}, {{(NR*DW-1){1'b0}}, sdo},
          {{(NR*DW-1){1'b0}}, (arm0 && k < 18) ? rb[17-k] : 1'b0});
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    sen = 1;
    repeat (8) @(negedge clk);
    model_commit(n, st);
    chk({req, " bus"}, regs_flat, exp_flat());
    chk({req, " R8 sdo idle"}, {{(NR*DW-1){1'b0}}, sdo}, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R9 reset bus", regs_flat, exp_flat());
    chk("R9 reset sdo", {{(NR*DW-1){1'b0}}, sdo}, '0);

    frame(24, {8'h0, 18'h2ABCD, 6'h05}, "R1 basic");
    frame(24, {8'h0, 18'h3FFFF, REV}, "R6 rev write");
    chk("R6 rev const", regs_flat, exp_flat());
    frame(24, {8'h0, 18'h00005, REV}, "R7 arm");
    frame(24, {8'h0, 18'h11111, FREE}, "R7 readback with write");
    frame(24, {8'h0, 18'h00005, REV}, "R8 rearm");
    frame(24, {8'h0, 18'h01234, 6'h07}, "R8 disarm by write");
    frame(20, {12'h0, 14'h3AAA, 6'h08}, "R4 short");
    frame(28, {4'hF, 18'h15555, 6'h09}, "R3 long");
    sleep_n = 1;
    frame(24, {8'h0, 18'h3C3C3, 6'h0A}, "R5 refused");
    frame(24, {8'h0, 18'h0F0F0, FREE}, "R5 exempt");
    sleep_n = 0;
    repeat (10) begin
      sdi = 1;
      repeat (3) @(negedge clk);
      sclk = 1;
      repeat (3) @(negedge clk);
      sclk = 0;
    end
    frame(20, {12'h0, 14'h1234, 6'h0B}, "R2 sen high clocks");

    for (int t = 0; t < 60; t++) begin
      logic [5:0] a;
      logic [17:0] d;
      int n, r;
      r = $urandom % 8;
      n = (r == 0) ? 20 : (r == 1) ? 28 : 24;
      r = $urandom % 6;
      a = (r == 0) ? REV : (r == 1) ? FREE : 6'($urandom);
      d = 18'($urandom);
      if (a == REV) d[5:0] = (r == 0 && ($urandom % 2)) ? REV : 6'($urandom % 12);
      sleep_n = ($urandom % 4) == 0;
      frame(n, {8'($urandom), d, a}, "R1 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule